// File: doc/BRIEF.md
# Instruction Reuse Buffer

This block is a small memoization table placed next to the issue stage of an out-of-order core. An instruction presents its address, its opcode and its two operand values. If an entry indexed by that address holds the same operand values, the block returns the result saved in that entry within the same cycle, so the instruction does not need to execute. Some operations have an obvious result, such as adding zero or multiplying by one. The block detects these from the opcode and operands and returns the result without reading the table.

The table is filled at commit time. An instruction that missed on lookup, or that could not query at all, presents its address, operands and result on the update port, and the block places the result in one of the two ways of the indexed set. A per-entry lock input comes from the result-forwarding logic and protects entries whose results are still being read by consumers. A locked entry is never chosen for replacement. A hit also reports a combined entry number made of the set index and the way, so a later stage can refer to the entry.

Top module: `instruction_reuse_buffer`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) invalidates every entry, so no table hit is reported afterwards until an update refills the table.
- R2: A query with q_valid high whose address tag and both operands equal a valid entry of the set selected by q_pc[PC_LSB+IDX_W-1:PC_LSB] raises q_hit in the same cycle. It returns the stored result on q_result and returns {set, way} on q_entry, with way 0 in the LSB.
- R3: A query whose address matches a valid entry but whose operand a or operand b differs from the stored value reports no hit.
- R4: A rising edge with u_valid high writes tag, operands and result into the set indexed by u_pc. The lowest-numbered unlocked invalid way is chosen first.
- R5: When both ways of a set are valid, an update replaces the least recently used way. A table hit or a write marks the way it touches as most recently used.
- R6: When the opcode and operands give a trivial result, q_trivial is high, q_hit is low and q_result holds that result. In this case the table's replacement state is unchanged.
- R7: An update never overwrites an entry whose lock_vec bit (index {set, way}) is high. If the least recently used way is locked, the other way is used when it is unlocked.
- R8: If both ways of the target set are locked, the update is dropped, and the contents of both entries stay as they were.
- R9: A query in the same cycle as an update to the same set sees the contents from before that update.
- R10: With q_valid low, q_hit and q_trivial are low.
- R11: Opcode codes are ADD=0, SUB=1, MUL=2, AND=3, OR=4, XOR=5, SHL=6, OTHER=7. The trivial cases are:
  - ADD: a=0 gives b, b=0 gives a.
  - SUB: b=0 gives a, a=b gives 0.
  - MUL: an operand of 0 gives 0, a=1 gives b, b=1 gives a.
  - AND: an operand of 0 gives 0, a=b gives a.
  - OR and XOR: a=0 gives b, b=0 gives a; for a=b, OR gives a and XOR gives 0.
  - SHL: b=0 gives a, a=0 gives 0.
  - OTHER is never trivial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| q_valid | input | 1 | Query present |
| q_pc | input | PC_W | Address of the querying instruction |
| q_op | input | 3 | Opcode code of the querying instruction |
| q_a | input | DATA_W | First operand value |
| q_b | input | DATA_W | Second operand value |
| q_hit | output | 1 | Table hit on address and both operands |
| q_trivial | output | 1 | Result follows from the operands alone |
| q_result | output | DATA_W | Reused or trivial result |
| q_entry | output | ENT_W | Entry number {set, way} of the hit |
| u_valid | input | 1 | Commit-time fill request |
| u_pc | input | PC_W | Address of the committing instruction |
| u_a | input | DATA_W | First operand to store |
| u_b | input | DATA_W | Second operand to store |
| u_result | input | DATA_W | Result to store |
| lock_vec | input | ENTRIES | Per-entry lock; a set bit protects that entry |

## Verification
On every cycle, the assertions check that a write never lands on a locked entry, that at most one way matches a query, and that a trivial outcome never shows as a table hit. They also check that hits and writes occur only with their request signals, and that reset empties the valid bits. Only the bench scenarios can show the behaviour over several cycles. This covers which way an update takes given the replacement history, an update being dropped when the set is locked, a query seeing old contents during a same-cycle fill, and the exact result value for each trivial opcode rule.

// File: rtl/rb_pkg.sv
package rb_pkg;
    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_MUL   = 3'd2,
        OP_AND   = 3'd3,
        OP_OR    = 3'd4,
        OP_XOR   = 3'd5,
        OP_SHL   = 3'd6,
        OP_OTHER = 3'd7
    } rb_op_e;

    localparam int OP_W = 3;
endpackage

// File: rtl/rb_trivial_detect.sv
module rb_trivial_detect
    import rb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              trivial,
    output logic [DATA_W-1:0] result
);
    localparam logic [DATA_W-1:0] ZERO = '0;
    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);

    logic a_zero, b_zero, a_one, b_one, same;

    always_comb begin
        a_zero  = (a == ZERO);
        b_zero  = (b == ZERO);
        a_one   = (a == ONE);
        b_one   = (b == ONE);
        same    = (a == b);
        trivial = 1'b0;
        result  = ZERO;
        unique case (rb_op_e'(op))
            OP_ADD: begin
                if (a_zero)      begin trivial = 1'b1; result = b; end
                else if (b_zero) begin trivial = 1'b1; result = a; end
            end
            OP_SUB: begin
                if (b_zero)      begin trivial = 1'b1; result = a; end
                else if (same)   begin trivial = 1'b1; result = ZERO; end
            end
            OP_MUL: begin
                if (a_zero || b_zero) begin trivial = 1'b1; result = ZERO; end
                else if (a_one)       begin trivial = 1'b1; result = b; end
                else if (b_one)       begin trivial = 1'b1; result = a; end
            end
            OP_AND: begin
                if (a_zero || b_zero) begin trivial = 1'b1; result = ZERO; end
                else if (same)        begin trivial = 1'b1; result = a; end
            end
            OP_OR: begin
                if (a_zero)      begin trivial = 1'b1; result = b; end
                else if (b_zero) begin trivial = 1'b1; result = a; end
                else if (same)   begin trivial = 1'b1; result = a; end
            end
            OP_XOR: begin
                if (same)        begin trivial = 1'b1; result = ZERO; end
                else if (a_zero) begin trivial = 1'b1; result = b; end
                else if (b_zero) begin trivial = 1'b1; result = a; end
            end
            OP_SHL: begin
                if (b_zero)      begin trivial = 1'b1; result = a; end
                else if (a_zero) begin trivial = 1'b1; result = ZERO; end
            end
            default: begin
                trivial = 1'b0;
                result  = ZERO;
            end
        endcase
    end
endmodule

// File: rtl/rb_way_compare.sv
module rb_way_compare #(
    parameter int TAG_W  = 23,
    parameter int DATA_W = 32
) (
    input  logic              ent_valid,
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic [DATA_W-1:0] ent_a,
    input  logic [DATA_W-1:0] ent_b,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [DATA_W-1:0] req_a,
    input  logic [DATA_W-1:0] req_b,
    output logic              match
);
    always_comb begin
        match = ent_valid && (ent_tag == req_tag) && (ent_a == req_a) && (ent_b == req_b);
    end
endmodule

// File: rtl/rb_victim_select.sv
module rb_victim_select (
    input  logic [1:0] way_valid,
    input  logic [1:0] way_lock,
    input  logic       lru_way,
    output logic       ok,
    output logic       way
);
    logic [1:0] free;

    always_comb begin
        free = ~way_lock;
        ok   = 1'b1;
        way  = 1'b0;
        if (free[0] && !way_valid[0]) begin
            way = 1'b0;
        end else if (free[1] && !way_valid[1]) begin
            way = 1'b1;
        end else if (free[lru_way]) begin
            way = lru_way;
        end else if (free[~lru_way]) begin
            way = ~lru_way;
        end else begin
            ok  = 1'b0;
        end
    end
endmodule

// File: rtl/instruction_reuse_buffer.sv
module instruction_reuse_buffer
    import rb_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int DATA_W  = 32,
    parameter int SETS    = 128,
    parameter int PC_LSB  = 2,
    localparam int ENTRIES = SETS * 2,
    localparam int ENT_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               q_valid,
    input  logic [PC_W-1:0]    q_pc,
    input  logic [OP_W-1:0]    q_op,
    input  logic [DATA_W-1:0]  q_a,
    input  logic [DATA_W-1:0]  q_b,
    output logic               q_hit,
    output logic               q_trivial,
    output logic [DATA_W-1:0]  q_result,
    output logic [ENT_W-1:0]   q_entry,
    input  logic               u_valid,
    input  logic [PC_W-1:0]    u_pc,
    input  logic [DATA_W-1:0]  u_a,
    input  logic [DATA_W-1:0]  u_b,
    input  logic [DATA_W-1:0]  u_result,
    input  logic [ENTRIES-1:0] lock_vec
);
    localparam int WAYS  = 2;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = PC_W - PC_LSB - IDX_W;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] res;
    } entry_t;

    typedef struct packed {
        logic [ENTRIES-1:0] valid;
        logic [SETS-1:0]    lru;
    } ctl_t;

    ctl_t   ctl_d, ctl_q;
    entry_t mem_d [ENTRIES];
    entry_t mem_q [ENTRIES];

    logic [IDX_W-1:0]  q_set, u_set;
    logic [TAG_W-1:0]  q_tag, u_tag;
    logic [WAYS-1:0]   way_hit;
    logic              hit_way;
    logic              tbl_hit;
    logic              triv;
    logic [DATA_W-1:0] triv_res;
    logic [1:0]        u_way_valid, u_way_lock;
    logic              wr_ok, wr_way, wr_en;
    logic [ENT_W-1:0]  wr_entry;

    assign q_set = q_pc[PC_LSB +: IDX_W];
    assign q_tag = q_pc[PC_W-1 -: TAG_W];
    assign u_set = u_pc[PC_LSB +: IDX_W];
    assign u_tag = u_pc[PC_W-1 -: TAG_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [ENT_W-1:0] q_idx, u_idx;
        assign q_idx = {q_set, 1'(w)};
        assign u_idx = {u_set, 1'(w)};
        assign u_way_valid[w] = ctl_q.valid[u_idx];
        assign u_way_lock[w]  = lock_vec[u_idx];

        rb_way_compare #(
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W)
        ) i_cmp (
            .ent_valid (ctl_q.valid[q_idx]),
            .ent_tag   (mem_q[q_idx].tag),
            .ent_a     (mem_q[q_idx].a),
            .ent_b     (mem_q[q_idx].b),
            .req_tag   (q_tag),
            .req_a     (q_a),
            .req_b     (q_b),
            .match     (way_hit[w])
        );
    end

    rb_trivial_detect #(
        .DATA_W (DATA_W)
    ) i_triv (
        .op      (q_op),
        .a       (q_a),
        .b       (q_b),
        .trivial (triv),
        .result  (triv_res)
    );

    rb_victim_select i_victim (
        .way_valid (u_way_valid),
        .way_lock  (u_way_lock),
        .lru_way   (ctl_q.lru[u_set]),
        .ok        (wr_ok),
        .way       (wr_way)
    );

    assign hit_way  = way_hit[1];
    assign wr_en    = u_valid && wr_ok;
    assign wr_entry = {u_set, wr_way};

    always_comb begin
        tbl_hit   = q_valid && !triv && (|way_hit);
        q_trivial = q_valid && triv;
        q_hit     = tbl_hit;
        q_entry   = {q_set, hit_way};
        if (triv) begin
            q_result = triv_res;
        end else begin
            q_result = mem_q[{q_set, hit_way}].res;
        end
    end

    always_comb begin
        ctl_d = ctl_q;
        mem_d = mem_q;
        if (tbl_hit) begin
            ctl_d.lru[q_set] = ~hit_way;
        end
        if (wr_en) begin
            mem_d[wr_entry]       = '{tag: u_tag, a: u_a, b: u_b, res: u_result};
            ctl_d.valid[wr_entry] = 1'b1;
            ctl_d.lru[u_set]      = ~wr_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end
endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
    parameter int ENTRIES = 256,
    parameter int ENT_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               q_valid,
    input logic               q_hit,
    input logic               q_trivial,
    input logic [1:0]         way_hit,
    input logic               u_valid,
    input logic               wr_en,
    input logic [ENT_W-1:0]   wr_entry,
    input logic [ENTRIES-1:0] lock_vec,
    input logic [ENTRIES-1:0] valid_q
);
    a_r1_reset_empties: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0));

    a_r2_hit_needs_query: assert property (@(posedge clk) disable iff (!rst_n)
        q_hit |-> q_valid);

    a_r3_one_way_matches: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    a_r4_write_needs_update: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> u_valid);

    a_r6_trivial_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
        q_trivial |-> !q_hit);

    a_r7_locked_not_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !lock_vec[wr_entry]);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> (!q_hit && !q_trivial));
endmodule

bind instruction_reuse_buffer rb_checker #(
    .ENTRIES (ENTRIES),
    .ENT_W   (ENT_W)
) i_rb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_valid   (q_valid),
    .q_hit     (q_hit),
    .q_trivial (q_trivial),
    .way_hit   (way_hit),
    .u_valid   (u_valid),
    .wr_en     (wr_en),
    .wr_entry  (wr_entry),
    .lock_vec  (lock_vec),
    .valid_q   (ctl_q.valid)
);

// File: tb/test_instruction_reuse_buffer.sv
`timescale 1ns/1ps
module test_instruction_reuse_buffer;
    localparam int PC_W = 32, DW = 32, SETS = 128, ENTRIES = 256, ENT_W = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic q_valid, q_hit, q_trivial;
    logic [PC_W-1:0] q_pc, u_pc;
    logic [2:0] q_op;
    logic [DW-1:0] q_a, q_b, q_result, u_a, u_b, u_result;
    logic [ENT_W-1:0] q_entry;
    logic u_valid;
    logic [ENTRIES-1:0] lock_vec;

    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    instruction_reuse_buffer i_instruction_reuse_buffer (
        .clk(clk), .rst_n(rst_n),
        .q_valid(q_valid), .q_pc(q_pc), .q_op(q_op), .q_a(q_a), .q_b(q_b),
        .q_hit(q_hit), .q_trivial(q_trivial), .q_result(q_result), .q_entry(q_entry),
        .u_valid(u_valid), .u_pc(u_pc), .u_a(u_a), .u_b(u_b), .u_result(u_result),
        .lock_vec(lock_vec)
    );

    function automatic logic [PC_W-1:0] mkpc(int tag, int set);
        return PC_W'((tag << 9) | (set << 2));
    endfunction

    task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic query(logic [PC_W-1:0] pc, logic [2:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
        @(negedge clk);
        u_valid = 1'b0;
        q_valid = 1'b1; q_pc = pc; q_op = op; q_a = a; q_b = b;
        #2;
    endtask

    task automatic update(logic [PC_W-1:0] pc, logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] r);
        @(negedge clk);
        q_valid = 1'b0;
        u_valid = 1'b1; u_pc = pc; u_a = a; u_b = b; u_result = r;
        @(posedge clk);
        #1 u_valid = 1'b0;
    endtask

    task automatic expect_hit(string req, logic [PC_W-1:0] pc, logic [DW-1:0] a, logic [DW-1:0] b,
                              logic [DW-1:0] r, logic [ENT_W-1:0] ent);
        query(pc, 3'd7, a, b);
        chk(req, "hit", DW'(q_hit), 1);
        chk(req, "result", q_result, r);
        chk(req, "entry", DW'(q_entry), DW'(ent));
    endtask

    task automatic expect_miss(string req, logic [PC_W-1:0] pc, logic [DW-1:0] a, logic [DW-1:0] b);
        query(pc, 3'd7, a, b);
        chk(req, "miss", DW'(q_hit), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; q_valid = 1'b0; u_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        // R1: after reset nothing hits
        expect_miss("R1", mkpc(1, 3), 32'h11, 32'h22);
    endtask

    task automatic t_basic();
        update(mkpc(1, 3), 32'h11, 32'h22, 32'h33);
        expect_hit("R2", mkpc(1, 3), 32'h11, 32'h22, 32'h33, 8'd6);
        expect_hit("R4", mkpc(1, 3), 32'h11, 32'h22, 32'h33, 8'd6);
        expect_miss("R3", mkpc(1, 3), 32'h12, 32'h22);
        expect_miss("R3", mkpc(1, 3), 32'h11, 32'h23);
        expect_miss("R2", mkpc(2, 3), 32'h11, 32'h22);
    endtask

    task automatic t_lru();
        update(mkpc(10, 5), 32'hA, 32'h1A, 32'hAA);
        update(mkpc(11, 5), 32'hB, 32'h1B, 32'hBB);
        expect_hit("R4", mkpc(11, 5), 32'hB, 32'h1B, 32'hBB, 8'd11);
        expect_hit("R5", mkpc(10, 5), 32'hA, 32'h1A, 32'hAA, 8'd10);
        update(mkpc(12, 5), 32'hC, 32'h1C, 32'hCC);
        expect_miss("R5", mkpc(11, 5), 32'hB, 32'h1B);
        expect_hit("R5", mkpc(12, 5), 32'hC, 32'h1C, 32'hCC, 8'd11);
        expect_hit("R5", mkpc(10, 5), 32'hA, 32'h1A, 32'hAA, 8'd10);
    endtask

    task automatic t_lock();
        // set 5: way0=A, way1=C; LRU victim currently way1 (A touched last)
        lock_vec[10] = 1'b1; lock_vec[11] = 1'b1;
        update(mkpc(13, 5), 32'hD, 32'h1D, 32'hDD);
        expect_miss("R8", mkpc(13, 5), 32'hD, 32'h1D);
        expect_hit("R8", mkpc(12, 5), 32'hC, 32'h1C, 32'hCC, 8'd11);
        expect_hit("R8", mkpc(10, 5), 32'hA, 32'h1A, 32'hAA, 8'd10);
        // now LRU victim is way1 (C); lock it so update must take way0
        lock_vec[10] = 1'b0;
        update(mkpc(13, 5), 32'hD, 32'h1D, 32'hDD);
        expect_hit("R7", mkpc(13, 5), 32'hD, 32'h1D, 32'hDD, 8'd10);
        expect_miss("R7", mkpc(10, 5), 32'hA, 32'h1A);
        expect_hit("R7", mkpc(12, 5), 32'hC, 32'h1C, 32'hCC, 8'd11);
        lock_vec = '0;
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        q_valid = 1'b1; q_pc = mkpc(20, 9); q_op = 3'd7; q_a = 32'h5; q_b = 32'h6;
        u_valid = 1'b1; u_pc = mkpc(20, 9); u_a = 32'h5; u_b = 32'h6; u_result = 32'h77;
        #2;
        chk("R9", "old contents", DW'(q_hit), 0);
        @(posedge clk);
        #1 u_valid = 1'b0;
        #2;
        chk("R9", "new contents hit", DW'(q_hit), 1);
        chk("R9", "new result", q_result, 32'h77);
    endtask

    task automatic t_idle();
        query(mkpc(1, 3), 3'd0, 32'h0, 32'h5);
        q_valid = 1'b0; #1;
        chk("R10", "hit idle", DW'(q_hit), 0);
        chk("R10", "trivial idle", DW'(q_trivial), 0);
    endtask

    task automatic triv(string req, logic [2:0] op, logic [DW-1:0] a, logic [DW-1:0] b,
                        logic exp_t, logic [DW-1:0] exp_r);
        query(mkpc(30, 40), op, a, b);
        chk(req, "trivial flag", DW'(q_trivial), DW'(exp_t));
        chk(req, "hit low", DW'(q_hit), 0);
        if (exp_t) chk(req, "trivial result", q_result, exp_r);
    endtask

    task automatic t_trivial();
        triv("R11", 3'd0, 32'h0, 32'h9, 1, 32'h9);
        triv("R11", 3'd0, 32'h7, 32'h0, 1, 32'h7);
        triv("R11", 3'd0, 32'h7, 32'h3, 0, 0);
        triv("R11", 3'd1, 32'h8, 32'h8, 1, 32'h0);
        triv("R11", 3'd2, 32'h1, 32'h44, 1, 32'h44);
        triv("R11", 3'd2, 32'h45, 32'h0, 1, 32'h0);
        triv("R11", 3'd3, 32'h6, 32'h6, 1, 32'h6);
        triv("R11", 3'd4, 32'h0, 32'h3, 1, 32'h3);
        triv("R11", 3'd5, 32'h3, 32'h3, 1, 32'h0);
        triv("R11", 3'd6, 32'h3, 32'h0, 1, 32'h3);
        triv("R11", 3'd7, 32'h0, 32'h0, 0, 0);
        // R6: trivial op whose address/operands also sit in the table
        update(mkpc(31, 41), 32'h0, 32'h4, 32'h99);
        query(mkpc(31, 41), 3'd0, 32'h0, 32'h4);
        chk("R6", "trivial wins", DW'(q_trivial), 1);
        chk("R6", "no table hit", DW'(q_hit), 0);
        chk("R6", "trivial value", q_result, 32'h4);
    endtask

    task automatic t_trivial_lru();
        // R6: trivial queries do not touch LRU. Fill set 50 with P (way0), Q (way1).
        update(mkpc(40, 50), 32'h0, 32'h2, 32'h50);
        update(mkpc(41, 50), 32'h3, 32'h4, 32'h51);
        // P is trivial as ADD (a=0); its table-hit would make Q the victim
        query(mkpc(40, 50), 3'd0, 32'h0, 32'h2);
        update(mkpc(42, 50), 32'h5, 32'h6, 32'h52);
        // victim must be way0 (P), since LRU pointed at way0 after Q's write
        expect_miss("R6", mkpc(40, 50), 32'h0, 32'h2);
        expect_hit("R6", mkpc(41, 50), 32'h3, 32'h4, 32'h51, 8'd101);
    endtask

    task automatic t_reset_again();
        do_reset();
        expect_miss("R1", mkpc(13, 5), 32'hD, 32'h1D);
        expect_miss("R1", mkpc(20, 9), 32'h5, 32'h6);
    endtask

    initial begin
        rst_n = 1'b0; q_valid = 1'b0; u_valid = 1'b0; lock_vec = '0;
        q_pc = '0; q_op = '0; q_a = '0; q_b = '0;
        u_pc = '0; u_a = '0; u_b = '0; u_result = '0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_basic();
        t_lru();
        t_lock();
        t_same_cycle();
        t_idle();
        t_trivial();
        t_trivial_lru();
        t_reset_again();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule